// File: doc/BRIEF.md
# Broadcast Invalidation Controller

This block sits beside the directory of a shared memory cache. Each time a line is evicted, or a write lands on a line held by other caches, the directory offers an event that carries the line index and the number of cached copies. When the copy count is above a threshold that software programs, the block sends one invalidation to every cache at once instead of naming each sharer. Events at or below the threshold are passed back with a one-cycle `direct_o` pulse, so that the targeted path can handle them. That targeted path is outside this block.

A broadcast goes out as a single-flit write to a fixed broadcast address. The line index travels in the write-data field and in the two lowest byte-enable bits. Only caches that hold a copy reply. A cache that holds the line in both its instruction array and its data array replies twice, so the copy count supplied counts each array copy. The block stores that count at launch, counts the replies one by one, and signals completion with a one-cycle `done_o` pulse.

The controller has four states, listed in the table below.

| State | Meaning |
|-------|---------|
| ST_IDLE | Waiting for an event. |
| ST_ISSUE | Presenting the command. |
| ST_WAIT | Counting replies. |
| ST_DONE | Completion cycle. |

It has five transitions, listed in the table below.

| Transition | Condition |
|------------|-----------|
| IDLE to ISSUE | An event is accepted with a copy count above the threshold. |
| IDLE to IDLE | An event is accepted with a copy count at or below the threshold, and `direct_o` pulses. |
| ISSUE to WAIT | `cmd_ready_i` is high at a clock edge. |
| WAIT to DONE | The reply arrives that brings the count to the stored total. |
| DONE to IDLE | Always, on the next cycle. |

Top module: `bcast_inval_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE. `evt_ready_o` is 1, and `cmd_valid_o`, `busy_o`, `done_o`, `direct_o` and `err_o` are all 0.
- R2: An event is accepted when `evt_valid_i` and `evt_ready_o` are both high at a clock edge. If `evt_sharers_i` is strictly greater than `thresh_i`, `cmd_valid_o` is 1 from the next cycle. Otherwise no command is raised, `direct_o` is 1 for exactly the next cycle, and the block stays idle.
- R3: While `cmd_valid_o` is high, the command fields hold fixed values. `cmd_op_o` is 2'b10, the write opcode. `cmd_addr_o` is 3, meaning only bits 1:0 are set. `cmd_wdata_o` equals bits DATA_W-1:0 of the accepted line index. `cmd_be_o` bits 1:0 equal line index bits DATA_W+1:DATA_W, and all higher `cmd_be_o` bits are 0.
- R4: `cmd_valid_o` and every command field stay unchanged until `cmd_ready_i` is high at a clock edge. `cmd_valid_o` is 0 in the cycle after that edge.
- R5: The copy count is stored at launch. Each cycle with `rsp_valid_i` high in ST_WAIT counts one reply. `done_o` is 1 in the cycle after the reply that brings the count to the stored total, and not earlier.
- R6: `done_o` stays high for exactly one cycle. In the cycle after it, the block is idle again with `evt_ready_o` at 1 and `busy_o` at 0.
- R7: From launch until the end of the done cycle, `evt_ready_o` is 0 and `busy_o` is 1. Events offered during this time are not taken and do not change the command fields.
- R8: A reply that arrives outside ST_WAIT sets `err_o`, and `err_o` stays at 1 until reset. Such a reply does not advance the count, so a later broadcast still needs its full number of replies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh_i | input | CNT_W | Copy-count threshold for the broadcast decision |
| evt_valid_i | input | 1 | Event offered (eviction or write to shared line) |
| evt_ready_o | output | 1 | Block can take an event |
| evt_line_i | input | DATA_W+2 | Line index of the event |
| evt_sharers_i | input | CNT_W | Number of cached copies, each array copy counted separately |
| direct_o | output | 1 | One-cycle pulse: event handled by the targeted path |
| cmd_valid_o | output | 1 | Broadcast command present |
| cmd_ready_i | input | 1 | Network takes the command |
| cmd_op_o | output | 2 | Command opcode (write) |
| cmd_addr_o | output | ADDR_W | Broadcast address |
| cmd_wdata_o | output | DATA_W | Low part of the line index |
| cmd_be_o | output | DATA_W/8 | Byte enables, with bits 1:0 holding the top of the line index |
| rsp_valid_i | input | 1 | One reply in this cycle |
| busy_o | output | 1 | A broadcast is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky flag for a stray reply |

## Verification
The hardest conditions to reach are those in which the controller sees input it should refuse. These are new events offered while a command is held by back-pressure, and replies that arrive while the command is still waiting for the network. The bench sweeps every pair of threshold and copy count in a 4-bit configuration. For each broadcast it varies the back-pressure length and the gaps between replies, and it offers junk events during the held cycles. Afterwards it injects a stray reply during ST_ISSUE and another in ST_IDLE. It then confirms that `err_o` stays set and that a later broadcast still needs its exact reply count.

// File: rtl/bic_pkg.sv
package bic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } bic_state_e;

    localparam logic [1:0] OP_WRITE      = 2'b10;
    localparam logic [1:0] BCAST_ADDR_LO = 2'b11;

endpackage

// File: rtl/bic_launch_dec.sv
module bic_launch_dec #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] sharers_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             bcast_o
);
    // Strictly above the threshold takes the broadcast path.
    always_comb begin
        bcast_o = (sharers_i > thresh_i);
    end
endmodule

// File: rtl/bic_cmd_reg.sv
module bic_cmd_reg
    import bic_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [DATA_W+1:0]   line_i,
    output logic [1:0]          op_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [DATA_W/8-1:0] be_o
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            hi_q    <= '0;
        end else if (load_i) begin
            wdata_q <= line_i[DATA_W-1:0];
            hi_q    <= line_i[DATA_W+1:DATA_W];
        end
    end

    always_comb begin
        op_o    = OP_WRITE;
        addr_o  = {{(ADDR_W-2){1'b0}}, BCAST_ADDR_LO};
        wdata_o = wdata_q;
        be_o    = {{(BE_W-2){1'b0}}, hi_q};
    end
endmodule

// File: rtl/bic_rsp_counter.sv
module bic_rsp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             inc_i,
    output logic             last_o
);
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            total_q <= total_i;
            cnt_q   <= '0;
        end else if (inc_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        last_o = inc_i && ((cnt_q + 1'b1) == total_q);
    end

    // R5: count never passes the stored total
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= total_q);
endmodule

// File: rtl/bcast_inval_ctrl.sv
module bcast_inval_ctrl
    import bic_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    thresh_i,
    input  logic                evt_valid_i,
    output logic                evt_ready_o,
    input  logic [DATA_W+1:0]   evt_line_i,
    input  logic [CNT_W-1:0]    evt_sharers_i,
    output logic                direct_o,
    output logic                cmd_valid_o,
    input  logic                cmd_ready_i,
    output logic [1:0]          cmd_op_o,
    output logic [ADDR_W-1:0]   cmd_addr_o,
    output logic [DATA_W-1:0]   cmd_wdata_o,
    output logic [DATA_W/8-1:0] cmd_be_o,
    input  logic                rsp_valid_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o
);
    bic_state_e state_q, state_d;
    logic accept, bcast, launch, last_rsp, count_en;
    logic direct_q, err_q;

    assign accept   = evt_valid_i && (state_q == ST_IDLE);
    assign launch   = accept && bcast;
    assign count_en = rsp_valid_i && (state_q == ST_WAIT);

    bic_launch_dec #(.CNT_W(CNT_W)) u_dec (
        .sharers_i (evt_sharers_i),
        .thresh_i  (thresh_i),
        .bcast_o   (bcast)
    );

    bic_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .line_i  (evt_line_i),
        .op_o    (cmd_op_o),
        .addr_o  (cmd_addr_o),
        .wdata_o (cmd_wdata_o),
        .be_o    (cmd_be_o)
    );

    bic_rsp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .total_i (evt_sharers_i),
        .inc_i   (count_en),
        .last_o  (last_rsp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)      state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready_i) state_d = ST_WAIT;
            ST_WAIT:  if (last_rsp)    state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Pulse and sticky flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            direct_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            direct_q <= accept && !bcast;
            if (rsp_valid_i && (state_q != ST_WAIT)) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        evt_ready_o = 1'b0;
        cmd_valid_o = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  evt_ready_o = 1'b1;
            ST_ISSUE: begin cmd_valid_o = 1'b1; busy_o = 1'b1; end
            ST_WAIT:  busy_o = 1'b1;
            ST_DONE:  begin done_o = 1'b1; busy_o = 1'b1; end
            default:  evt_ready_o = 1'b0;
        endcase
        direct_o = direct_q;
        err_o    = err_q;
    end

    // R2: a command only appears after an accepted event
    p_launch_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid_o) |-> $past(evt_valid_i && evt_ready_o));
    // R4: command held under back-pressure
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_wdata_o) && $stable(cmd_be_o)));
    // R6: done is a single-cycle pulse followed by idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && evt_ready_o));
    // R7: a direct pulse never happens during a broadcast
    p_direct_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        direct_o |-> !busy_o);
    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: tb/test_bcast_inval_ctrl.sv
module test_bcast_inval_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 40;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int BE_W   = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic evt_valid = 1'b0, evt_ready;
    logic [DATA_W+1:0] evt_line = '0;
    logic [CNT_W-1:0] evt_sharers = '0;
    logic direct, cmd_valid, cmd_ready = 1'b0;
    logic [1:0] cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [BE_W-1:0] cmd_be;
    logic rsp_valid = 1'b0, busy, done, err;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcast_inval_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_bcast_inval_ctrl (
        .clk(clk), .rst_n(rst_n), .thresh_i(thresh),
        .evt_valid_i(evt_valid), .evt_ready_o(evt_ready),
        .evt_line_i(evt_line), .evt_sharers_i(evt_sharers),
        .direct_o(direct), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
        .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
        .cmd_be_o(cmd_be), .rsp_valid_i(rsp_valid), .busy_o(busy),
        .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_fields(input logic [DATA_W+1:0] line, input string req);
        chk(cmd_op == 2'b10, req, "opcode", 64'(cmd_op), 64'h2);
        chk(cmd_addr == ADDR_W'(3), req, "address", 64'(cmd_addr), 64'h3);
        chk(cmd_wdata == line[DATA_W-1:0], req, "wdata", 64'(cmd_wdata), 64'(line[DATA_W-1:0]));
        chk(cmd_be == BE_W'(line[DATA_W+1:DATA_W]), req, "byte enables", 64'(cmd_be),
            64'(line[DATA_W+1:DATA_W]));
    endtask

    // Offers one event; for a broadcast drives back-pressure and replies.
    task automatic run_event(input logic [DATA_W+1:0] line, input int sh, input int th,
                             input int hold, input int gap);
        thresh      = CNT_W'(th);
        evt_line    = line;
        evt_sharers = CNT_W'(sh);
        chk(evt_ready == 1'b1, "R7", "ready before event", 64'(evt_ready), 64'h1);
        evt_valid = 1'b1;
        step();
        evt_valid = 1'b0;
        if (sh > th) begin
            chk(cmd_valid == 1'b1, "R2", "cmd raised", 64'(cmd_valid), 64'h1);
            chk(direct == 1'b0, "R2", "no direct pulse", 64'(direct), 64'h0);
            check_fields(line, "R3");
            for (int d = 0; d < hold; d++) begin
                evt_valid = 1'b1;
                evt_line  = ~line;
                evt_sharers = CNT_W'(sh + 1);
                step();
                chk(cmd_valid == 1'b1, "R4", "held valid", 64'(cmd_valid), 64'h1);
                chk(evt_ready == 1'b0 && busy == 1'b1, "R7", "ready low while busy",
                    64'({evt_ready, busy}), 64'h1);
                check_fields(line, "R4");
            end
            evt_valid = 1'b0;
            cmd_ready = 1'b1;
            step();
            cmd_ready = 1'b0;
            chk(cmd_valid == 1'b0, "R4", "valid dropped", 64'(cmd_valid), 64'h0);
            for (int k = 0; k < sh; k++) begin
                for (int g = 0; g < gap; g++) begin
                    step();
                    chk(done == 1'b0, "R5", "no early done", 64'(done), 64'h0);
                end
                rsp_valid = 1'b1;
                step();
                rsp_valid = 1'b0;
                chk(done == (k == sh - 1), "R5", "done after last reply",
                    64'(done), 64'(k == sh - 1));
            end
            step();
            chk(done == 1'b0 && evt_ready == 1'b1 && busy == 1'b0, "R6",
                "idle after done", 64'({done, evt_ready, busy}), 64'h2);
        end else begin
            chk(cmd_valid == 1'b0, "R2", "no cmd", 64'(cmd_valid), 64'h0);
            chk(direct == 1'b1, "R2", "direct pulse", 64'(direct), 64'h1);
            step();
            chk(direct == 1'b0, "R2", "direct one cycle", 64'(direct), 64'h0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        chk(evt_ready == 1'b1, "R1", "ready", 64'(evt_ready), 64'h1);
        chk({cmd_valid, busy, done, direct, err} == 5'b0, "R1", "outputs idle",
            64'({cmd_valid, busy, done, direct, err}), 64'h0);

        // Sweep every threshold and copy count of the 4-bit configuration
        for (int th = 0; th < 16; th++) begin
            for (int sh = 0; sh < 16; sh++) begin
                logic [DATA_W+1:0] line;
                line = {2'(th + sh), 32'hA500_0000 + 32'(th * 16 + sh)};
                run_event(line, sh, th, (th + sh) % 4, sh % 3);
            end
        end
        chk(err == 1'b0, "R8", "no error after clean sweep", 64'(err), 64'h0);

        // Stray reply while the command is held in ST_ISSUE
        thresh = 4'd1; evt_sharers = 4'd3; evt_line = 34'h2_1234_5678;
        evt_valid = 1'b1;
        step();
        evt_valid = 1'b0;
        rsp_valid = 1'b1;
        step();
        rsp_valid = 1'b0;
        chk(err == 1'b1, "R8", "stray in issue", 64'(err), 64'h1);
        cmd_ready = 1'b1;
        step();
        cmd_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            rsp_valid = 1'b1;
            step();
            rsp_valid = 1'b0;
            chk(done == (k == 2), "R8", "stray not counted", 64'(done), 64'(k == 2));
        end
        step();

        // Stray reply in idle after reset, then a full broadcast
        do_reset();
        chk(err == 1'b0, "R1", "err cleared by reset", 64'(err), 64'h0);
        rsp_valid = 1'b1;
        step();
        rsp_valid = 1'b0;
        chk(err == 1'b1, "R8", "stray in idle", 64'(err), 64'h1);
        chk(evt_ready == 1'b1, "R8", "state unchanged", 64'(evt_ready), 64'h1);
        run_event(34'h1_0F0F_0F0F, 5, 0, 2, 1);
        chk(err == 1'b1, "R8", "err sticky", 64'(err), 64'h1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule